// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 64-bit virtual address into a physical address plus a read/write/execute permission set, or into a fault code that says why the access cannot proceed. A walk is launched by a one-cycle `startI` together with the virtual address, the access being attempted (`needI`), a privilege-mode index (`modeI`, where 0 is the kernel) and the root table base. The walker fetches up to three 64-bit table entries through a plain request/acknowledge memory port. It finishes with a one-cycle `doneO`. The result stays on `paddrO`, `permO` and `faultO` until the next walk ends.

Some accesses never touch memory. A physical-access mode passes the address through untranslated. A malformed (not sign-extended) address faults at once. A directly mapped kernel window, the superpage, is relocated arithmetically. These complete one cycle after the start. Every other address walks three levels of 1024-entry tables with 8 KB pages and 43 implemented virtual-address bits. Only one walk is active at a time.

Top module: `pt_walker`

## Requirements
- R1: With `physModeI` high, the walk completes on the cycle after the start with no memory request: `paddrO` equals `vaddrI`, `permO` = 3'b111 (bit 0 read, bit 1 write, bit 2 execute), fault code 0 (none) and `okO` high. This holds even for addresses that would otherwise be malformed.
- R2: Outside physical mode, an address whose bits 63 down to 43 are not all equal completes on the next cycle with fault code 1 (access violation) and issues no memory read.
- R3: A well-formed address with bit 63 set and bits 42:41 = 2'b10 is a superpage. In mode 0 it yields `paddrO[39:0]` = `vaddrI[39:0]`, `paddrO[43]` = `vaddrI[40]`, all other bits 0, and `permO` = 3'b111. In any other mode it yields fault code 1. In both cases there is no memory read.
- R4: Any other address reads three entries in order. The entry address is the current table base plus 8 times a 10-bit index. The indices are `vaddrI[42:33]` for the first read, `vaddrI[32:23]` for the second and `vaddrI[22:13]` for the third. The first base is `ptBaseI`. Each following base is the fetched entry's bits 63:32 shifted left by 13.
- R5: `memReqO` stays high with `memAddrO` unchanged until `memAckI` is seen. `memDataI` is taken in the acknowledge cycle.
- R6: An entry with bit 0 (valid) clear, at any level, ends the walk with fault code 2 (not valid) and no further read.
- R7: At the first two levels, a valid entry with bit 8 (kernel read enable) clear ends the walk with fault code 1, whatever the mode.
- R8: In the last-level entry, bit 8+mode grants read and execute and bit 12+mode grants write. If `needI` is nonzero and none of its bits is granted, the fault code is 1.
- R9: Last-level bits 1, 2 and 3 withdraw read, write and execute respectively. If the needed access is then withdrawn, the fault code is 5 for execute, else 4 for write, else 3 for read. A zero `needI` never faults at this step.
- R10: On success, `paddrO` = last-level bits 63:32 shifted left by 13, OR `vaddrI[12:0]`, and `permO` is the grant after withdrawal. On any fault, `paddrO` and `permO` are 0. `okO` is high exactly in a done cycle with fault code 0.
- R11: `doneO` is a one-cycle pulse on the cycle after the final acknowledge. A `startI` seen while a walk is in progress is ignored, and the inputs are captured only at the accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startI | input | 1 | Launch a walk (taken only when idle) |
| vaddrI | input | 64 | Virtual address |
| needI | input | 3 | Access needed: bit 0 read, bit 1 write, bit 2 execute, at most one set |
| modeI | input | 2 | Privilege mode index, 0 = kernel |
| physModeI | input | 1 | Physical access, no translation |
| ptBaseI | input | 64 | Root page table base, 8-byte aligned |
| memReqO | output | 1 | Table entry read request |
| memAddrO | output | 64 | Table entry byte address |
| memAckI | input | 1 | Read acknowledge, data valid |
| memDataI | input | 64 | Table entry read data |
| doneO | output | 1 | Walk finished (one cycle) |
| okO | output | 1 | Walk finished without fault |
| paddrO | output | 64 | Physical address |
| permO | output | 3 | Granted permissions, same bit order as needI |
| faultO | output | 3 | 0 none, 1 access violation, 2 not valid, 3 read, 4 write, 5 execute fault |

## Verification
Two events can land on the same clock edge. One is the final entry acknowledge that ends a walk; the other is a fresh `startI`, which must be ignored. A related case is a start raised in the very cycle a done pulse shows. The bench holds `startI` high with a different address and mode for the whole of a walk. It then checks that every table address, and the final result, still match the first request. The done pulse must show once and then fall. Back-to-back short walks are also issued with starts landing right after each done pulse.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  typedef enum logic [2:0] {
    FLT_NONE = 3'd0,
    FLT_ACV  = 3'd1,
    FLT_TNV  = 3'd2,
    FLT_FOR  = 3'd3,
    FLT_FOW  = 3'd4,
    FLT_FOE  = 3'd5
  } fault_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic advance;
    logic finFast;
    logic finWalk;
  } ctl_s;

  // conditions from datapath to control
  typedef struct packed {
    logic fastHit;
    logic walkEnd;
  } sts_s;

  localparam int PTE_VALID_BIT = 0;
  localparam int PTE_FO_LSB    = 1;
  localparam int PTE_RD_LSB    = 8;
  localparam int PTE_WR_LSB    = 12;

endpackage

// File: rtl/pt_walker_dp.sv
module pt_walker_dp
  import pt_walker_pkg::*;
#(
  parameter int VA_BITS   = 43,
  parameter int PAGE_BITS = 13,
  parameter int IDX_BITS  = 10,
  parameter int LEVELS    = 3,
  parameter int MODE_W    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctl_s              ctl,
  output sts_s              sts,
  input  logic [63:0]       vaddrI,
  input  logic [2:0]        needI,
  input  logic [MODE_W-1:0] modeI,
  input  logic              physModeI,
  input  logic [63:0]       ptBaseI,
  input  logic [63:0]       memDataI,
  output logic [63:0]       memAddrO,
  output logic [63:0]       paddrO,
  output logic [2:0]        permO,
  output fault_e            faultO
);

  localparam int LVL_W = $clog2(LEVELS);
  localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

  logic [VA_BITS-1:0] vaR;
  logic [2:0]         needR;
  logic [MODE_W-1:0]  modeR;
  logic [63:0]        baseR;
  logic [LVL_W-1:0]   lvlR;
  logic [63:0]        paddrR;
  logic [2:0]         permR;
  fault_e             faultR;

  // ---------------- immediate (no memory) classification ----------------
  logic        signOk, isSuper;
  logic [63:0] fastPa;
  logic [2:0]  fastPerm;
  fault_e      fastFault;

  assign signOk  = (&vaddrI[63:VA_BITS]) | ~(|vaddrI[63:VA_BITS]);
  assign isSuper = vaddrI[63] & (vaddrI[42:41] == 2'b10);

  always_comb begin
    sts.fastHit = 1'b1;
    fastPa      = '0;
    fastPerm    = '0;
    fastFault   = FLT_NONE;
    if (physModeI) begin
      fastPa   = vaddrI;
      fastPerm = 3'b111;
    end else if (!signOk) begin
      fastFault = FLT_ACV;
    end else if (isSuper) begin
      if (modeI != '0) begin
        fastFault = FLT_ACV;
      end else begin
        fastPa[39:0] = vaddrI[39:0];
        fastPa[43]   = vaddrI[40];
        fastPerm     = 3'b111;
      end
    end else begin
      sts.fastHit = 1'b0;
    end
  end

  // ---------------- per-level index selection ----------------
  logic [IDX_BITS-1:0] idxTab [LEVELS];
  logic [IDX_BITS-1:0] idxSel;

  for (genvar g = 0; g < LEVELS; g++) begin : g_idx
    assign idxTab[g] = vaR[PAGE_BITS + IDX_BITS*(LEVELS-1-g) +: IDX_BITS];
  end

  always_comb begin
    idxSel = idxTab[0];
    for (int l = 0; l < LEVELS; l++) begin
      if (lvlR == LVL_W'(l)) idxSel = idxTab[l];
    end
  end

  assign memAddrO = baseR + (64'(idxSel) << 3);

  // ---------------- entry evaluation on the response ----------------
  logic        lastLvl, rdEn, wrEn;
  logic [2:0]  grant, kept;
  logic [63:0] nextBase;
  fault_e      walkFault;

  assign lastLvl  = (lvlR == LAST_LVL);
  assign nextBase = 64'(memDataI[63:32]) << PAGE_BITS;
  assign rdEn     = memDataI[PTE_RD_LSB + int'(modeR)];
  assign wrEn     = memDataI[PTE_WR_LSB + int'(modeR)];
  assign grant    = {rdEn, wrEn, rdEn};
  assign kept     = grant & ~memDataI[PTE_FO_LSB +: 3];

  always_comb begin
    walkFault = FLT_NONE;
    if (!memDataI[PTE_VALID_BIT]) begin
      walkFault = FLT_TNV;
    end else if (!lastLvl) begin
      if (!memDataI[PTE_RD_LSB]) walkFault = FLT_ACV;
    end else if ((needR != '0) && ((grant & needR) == '0)) begin
      walkFault = FLT_ACV;
    end else if ((needR != '0) && ((kept & needR) == '0)) begin
      if (needR[2])      walkFault = FLT_FOE;
      else if (needR[1]) walkFault = FLT_FOW;
      else               walkFault = FLT_FOR;
    end
  end

  assign sts.walkEnd = lastLvl | (walkFault != FLT_NONE);

  // ---------------- state ----------------
  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaR    <= '0;
      needR  <= '0;
      modeR  <= '0;
      baseR  <= '0;
      lvlR   <= '0;
      paddrR <= '0;
      permR  <= '0;
      faultR <= FLT_NONE;
    end else begin
      if (ctl.load) begin
        vaR   <= vaddrI[VA_BITS-1:0];
        needR <= needI;
        modeR <= modeI;
        baseR <= ptBaseI;
        lvlR  <= '0;
      end
      if (ctl.advance) begin
        baseR <= nextBase;
        lvlR  <= lvlR + 1'b1;
      end
      if (ctl.finFast) begin
        paddrR <= fastPa;
        permR  <= fastPerm;
        faultR <= fastFault;
      end
      if (ctl.finWalk) begin
        faultR <= walkFault;
        if (walkFault == FLT_NONE) begin
          paddrR <= nextBase | 64'(vaR[PAGE_BITS-1:0]);
          permR  <= kept;
        end else begin
          paddrR <= '0;
          permR  <= '0;
        end
      end
    end
  end

  assign paddrO = paddrR;
  assign permO  = permR;
  assign faultO = faultR;

endmodule

// File: rtl/pt_walker_ctl.sv
module pt_walker_ctl
  import pt_walker_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic startI,
  input  logic memAckI,
  input  sts_s sts,
  output ctl_s ctl,
  output logic memReqO,
  output logic doneO
);

  typedef enum logic {ST_IDLE, ST_WALK} state_e;

  state_e stateR;
  logic   doneR;

  always_comb begin
    ctl = '0;
    if (stateR == ST_IDLE && startI) begin
      ctl.load    = 1'b1;
      ctl.finFast = sts.fastHit;
    end
    if (stateR == ST_WALK && memAckI) begin
      ctl.advance = ~sts.walkEnd;
      ctl.finWalk = sts.walkEnd;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateR <= ST_IDLE;
      doneR  <= 1'b0;
    end else begin
      doneR <= ctl.finFast | ctl.finWalk;
      if (ctl.load && !ctl.finFast) stateR <= ST_WALK;
      else if (ctl.finWalk)         stateR <= ST_IDLE;
    end
  end

  assign memReqO = (stateR == ST_WALK);
  assign doneO   = doneR;

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int VA_BITS   = 43,
  parameter int PAGE_BITS = 13,
  parameter int IDX_BITS  = 10,
  parameter int LEVELS    = 3,
  parameter int MODE_W    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startI,
  input  logic [63:0]       vaddrI,
  input  logic [2:0]        needI,
  input  logic [MODE_W-1:0] modeI,
  input  logic              physModeI,
  input  logic [63:0]       ptBaseI,
  output logic              memReqO,
  output logic [63:0]       memAddrO,
  input  logic              memAckI,
  input  logic [63:0]       memDataI,
  output logic              doneO,
  output logic              okO,
  output logic [63:0]       paddrO,
  output logic [2:0]        permO,
  output logic [2:0]        faultO
);

  ctl_s   ctl;
  sts_s   sts;
  fault_e faultE;

  pt_walker_ctl u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .startI  (startI),
    .memAckI (memAckI),
    .sts     (sts),
    .ctl     (ctl),
    .memReqO (memReqO),
    .doneO   (doneO)
  );

  pt_walker_dp #(
    .VA_BITS   (VA_BITS),
    .PAGE_BITS (PAGE_BITS),
    .IDX_BITS  (IDX_BITS),
    .LEVELS    (LEVELS),
    .MODE_W    (MODE_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .sts       (sts),
    .vaddrI    (vaddrI),
    .needI     (needI),
    .modeI     (modeI),
    .physModeI (physModeI),
    .ptBaseI   (ptBaseI),
    .memDataI  (memDataI),
    .memAddrO  (memAddrO),
    .paddrO    (paddrO),
    .permO     (permO),
    .faultO    (faultE)
  );

  assign faultO = faultE;
  assign okO    = doneO & (faultE == FLT_NONE);

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk (
  input logic        clk,
  input logic        rstN,
  input logic        startI,
  input logic        memReqO,
  input logic [63:0] memAddrO,
  input logic        memAckI,
  input logic        doneO,
  input logic [63:0] paddrO,
  input logic [2:0]  permO,
  input logic [2:0]  faultO
);

  // R5: request and address held until acknowledged
  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    memReqO && !memAckI |=> memReqO && $stable(memAddrO));

  // R11: after an acknowledge, either the walk finishes or the next level is requested
  p_ack_next_r11: assert property (@(posedge clk) disable iff (!rstN)
    memReqO && memAckI |=> (doneO ^ memReqO));

  // R6: not-valid and fault-on codes arise only from a fetched entry
  p_mem_fault_r6: assert property (@(posedge clk) disable iff (!rstN)
    doneO && (faultO >= 3'd2) |-> $past(memAckI));

  // R10: faulted results carry no address and no permission
  p_fault_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    doneO && (faultO != 3'd0) |-> (paddrO == 64'd0) && (permO == 3'd0));

  // R1: a done pulse follows an idle start or an acknowledge
  p_done_cause_r1: assert property (@(posedge clk) disable iff (!rstN)
    doneO |-> $past(startI && !memReqO) || $past(memAckI));

endmodule

bind pt_walker pt_walker_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .startI   (startI),
  .memReqO  (memReqO),
  .memAddrO (memAddrO),
  .memAckI  (memAckI),
  .doneO    (doneO),
  .paddrO   (paddrO),
  .permO    (permO),
  .faultO   (faultO)
);

// File: tb/test_pt_walker.sv
module test_pt_walker;

  logic        clk = 1'b0;
  logic        rstN;
  logic        startI;
  logic [63:0] vaddrI;
  logic [2:0]  needI;
  logic [1:0]  modeI;
  logic        physModeI;
  logic [63:0] ptBaseI;
  logic        memReqO;
  logic [63:0] memAddrO;
  logic        memAckI;
  logic [63:0] memDataI;
  logic        doneO, okO;
  logic [63:0] paddrO;
  logic [2:0]  permO, faultO;

  int checks = 0;
  int errors = 0;

  logic [63:0] ptes    [3];
  logic [63:0] expAddr [3];
  int          memCnt   = 0;
  int          memDelay = 0;
  int          waitCnt  = 0;
  string       curTag   = "R4";

  localparam logic [63:0] BASE = 64'h0000_0000_0040_0000;
  localparam logic [31:0] F1   = 32'h0000_0155;
  localparam logic [31:0] F2   = 32'h0000_02AA;
  localparam logic [31:0] F3   = 32'h000A_BCDE;

  always #2 clk = ~clk;

  pt_walker i_pt_walker (
    .clk(clk), .rstN(rstN), .startI(startI), .vaddrI(vaddrI), .needI(needI),
    .modeI(modeI), .physModeI(physModeI), .ptBaseI(ptBaseI),
    .memReqO(memReqO), .memAddrO(memAddrO), .memAckI(memAckI), .memDataI(memDataI),
    .doneO(doneO), .okO(okO), .paddrO(paddrO), .permO(permO), .faultO(faultO)
  );

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // memory responder
  initial begin
    memAckI  = 1'b0;
    memDataI = '0;
    forever begin
      @(negedge clk);
      if (memAckI) begin
        memAckI = 1'b0;
      end else if (memReqO) begin
        if (waitCnt < memDelay) begin
          waitCnt++;
        end else begin
          waitCnt = 0;
          if (memCnt < 3) begin
            chk(memAddrO == expAddr[memCnt], curTag, memAddrO, expAddr[memCnt]);
            memDataI = ptes[memCnt];
          end else begin
            chk(1'b0, "R6 extra read", 64'(memCnt), 64'd3);
            memDataI = '0;
          end
          memCnt++;
          memAckI = 1'b1;
        end
      end
    end
  end

  // watchdog
  initial begin
    #(4 * 150000);
    checks++;
    errors++;
    $display("FAIL R11 watchdog act=hung exp=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic logic [63:0] vaOf(input logic [9:0] i1, input logic [9:0] i2,
                                       input logic [9:0] i3, input logic [12:0] off);
    vaOf = (64'(i1) << 33) | (64'(i2) << 23) | (64'(i3) << 13) | 64'(off);
  endfunction

  task automatic setAddrs(input logic [63:0] va);
    expAddr[0] = BASE + 64'(va[42:33]) * 8;
    expAddr[1] = (64'(F1) << 13) + 64'(va[32:23]) * 8;
    expAddr[2] = (64'(F2) << 13) + 64'(va[22:13]) * 8;
  endtask

  task automatic walk(input logic [63:0] va, input logic [2:0] need, input logic [1:0] mode,
                      input logic phys, input logic [2:0] eFault, input logic [63:0] ePa,
                      input logic [2:0] ePerm, input int eReads, input string tag,
                      input logic holdStart);
    int t = 0;
    curTag = tag;
    memCnt = 0;
    setAddrs(va);
    vaddrI = va; needI = need; modeI = mode; physModeI = phys; ptBaseI = BASE;
    startI = 1'b1;
    @(negedge clk);
    if (holdStart) begin
      vaddrI = ~va; needI = 3'b100; modeI = ~mode; physModeI = 1'b0; ptBaseI = 64'h8000;
    end else begin
      startI = 1'b0;
    end
    while (!doneO && t < 200) begin
      @(negedge clk);
      t++;
    end
    startI = 1'b0;
    chk(doneO, tag, 64'(doneO), 64'd1);
    chk(faultO == eFault, tag, 64'(faultO), 64'(eFault));
    chk(paddrO == ePa, tag, paddrO, ePa);
    chk(permO == ePerm, tag, 64'(permO), 64'(ePerm));
    chk(okO == (eFault == 3'd0), tag, 64'(okO), 64'(eFault == 3'd0));
    chk(memCnt == eReads, tag, 64'(memCnt), 64'(eReads));
    @(negedge clk);
    chk(!doneO, "R11 pulse", 64'(doneO), 64'd0);
  endtask

  function automatic logic [63:0] pte(input logic [31:0] frame, input logic [31:0] low);
    pte = {frame, low};
  endfunction

  initial begin
    logic [63:0] va;
    rstN = 1'b0; startI = 1'b0; vaddrI = '0; needI = '0; modeI = '0;
    physModeI = 1'b0; ptBaseI = BASE;
    repeat (3) @(negedge clk);
    chk(!doneO && !memReqO && !okO, "R11 reset", {doneO, memReqO, okO}, 3'b000);
    rstN = 1'b1;
    @(negedge clk);

    // R1 physical bypass, including a malformed address
    walk(64'h1234_5678_9ABC_DEF0, 3'b010, 2'd3, 1'b1, 3'd0, 64'h1234_5678_9ABC_DEF0, 3'b111, 0, "R1", 1'b0);
    walk(64'h0010_0000_0000_0000, 3'b001, 2'd0, 1'b1, 3'd0, 64'h0010_0000_0000_0000, 3'b111, 0, "R1", 1'b0);
    // R2 malformed addresses
    walk(64'h0010_0000_0000_0000, 3'b001, 2'd0, 1'b0, 3'd1, 64'd0, 3'd0, 0, "R2", 1'b0);
    walk(64'hFFFF_F000_0000_0000, 3'b001, 2'd0, 1'b0, 3'd1, 64'd0, 3'd0, 0, "R2", 1'b0);
    // R3 superpage
    walk(64'hFFFF_FD12_3456_789A, 3'b010, 2'd0, 1'b0, 3'd0, 64'h0000_0812_3456_789A, 3'b111, 0, "R3", 1'b0);
    walk(64'hFFFF_FC12_3456_789A, 3'b001, 2'd0, 1'b0, 3'd0, 64'h0000_0012_3456_789A, 3'b111, 0, "R3", 1'b0);
    walk(64'hFFFF_FD12_3456_789A, 3'b001, 2'd1, 1'b0, 3'd1, 64'd0, 3'd0, 0, "R3", 1'b0);

    // R6 not-valid at each level; R7 kernel read missing at levels 1 and 2
    va = vaOf(10'h2C5, 10'h13A, 10'h3FF, 13'h1ABC);
    ptes[0] = pte(F1, 32'h0000_0100); ptes[1] = pte(F2, 32'h0000_0100);
    ptes[2] = pte(F3, 32'h0000_1101);
    walk(va, 3'b001, 2'd0, 1'b0, 3'd2, 64'd0, 3'd0, 1, "R6", 1'b0);
    ptes[0] = pte(F1, 32'h0000_0101);
    walk(va, 3'b001, 2'd0, 1'b0, 3'd2, 64'd0, 3'd0, 2, "R6", 1'b0);
    ptes[1] = pte(F2, 32'h0000_0101); ptes[2] = pte(F3, 32'h0000_1100);
    walk(va, 3'b001, 2'd0, 1'b0, 3'd2, 64'd0, 3'd0, 3, "R6", 1'b0);
    ptes[0] = pte(F1, 32'h0000_0401);
    walk(va, 3'b001, 2'd2, 1'b0, 3'd1, 64'd0, 3'd0, 1, "R7", 1'b0);
    ptes[0] = pte(F1, 32'h0000_0101); ptes[1] = pte(F2, 32'h0000_0E01);
    walk(va, 3'b001, 2'd0, 1'b0, 3'd1, 64'd0, 3'd0, 2, "R7", 1'b0);

    // R11 start held high with different inputs during a walk
    ptes[1] = pte(F2, 32'h0000_0101); ptes[2] = pte(F3, 32'h0000_1101);
    memDelay = 2;
    walk(va, 3'b010, 2'd0, 1'b0, 3'd0, (64'(F3) << 13) | 64'h1ABC, 3'b111, 3, "R11", 1'b1);

    // negative but well-formed, non-superpage address walks (R4)
    va = 64'hFFFF_F800_0000_0000 | vaOf(10'h3C5, 10'h001, 10'h200, 13'h0007);
    memDelay = 0;
    walk(va, 3'b100, 2'd0, 1'b0, 3'd0, (64'(F3) << 13) | 64'h0007, 3'b111, 3, "R4", 1'b0);

    // R8 R9 R10 sweep: mode x need x leaf bit pattern
    va = vaOf(10'h0A3, 10'h35C, 10'h04E, 13'h0F0F);
    ptes[0] = pte(F1, 32'h0000_0101); ptes[1] = pte(F2, 32'h0000_0101);
    for (int m = 0; m < 4; m++) begin
      for (int ns = 0; ns < 4; ns++) begin
        for (int p = 0; p < 32; p++) begin
          logic [2:0] need, grant, kept, eFault, ePerm;
          logic [31:0] low;
          logic [63:0] ePa;
          logic re, we;
          re = p[0]; we = p[1];
          need = (ns == 0) ? 3'b000 : 3'(1 << (ns - 1));
          low = 32'h1 | (32'(p[4:2]) << 1);
          for (int o = 0; o < 4; o++) begin
            logic r2, w2;
            r2 = (o == m) ? re : ~re;
            w2 = (o == m) ? we : ~we;
            low = low | (32'(r2) << (8 + o)) | (32'(w2) << (12 + o));
          end
          ptes[2] = pte(F3, low);
          grant = {re, we, re};
          kept  = grant & ~3'(p[4:2]);
          eFault = 3'd0;
          if (need != 0 && (grant & need) == 0) eFault = 3'd1;
          else if (need != 0 && (kept & need) == 0)
            eFault = need[2] ? 3'd5 : (need[1] ? 3'd4 : 3'd3);
          ePerm = (eFault == 0) ? kept : 3'd0;
          ePa   = (eFault == 0) ? ((64'(F3) << 13) | 64'h0F0F) : 64'd0;
          memDelay = p % 3;
          walk(va, need, 2'(m), 1'b0, eFault, ePa, ePerm, 3,
               (eFault == 1) ? "R8" : ((eFault == 0) ? "R10" : "R9"), 1'b0);
        end
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule